// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

A two-port word store in which a left and a right port each read and write a shared array through their own control, address and data pins. Both ports run from one clock and act in the same cycle without waiting on each other. The two highest addresses also serve as mailboxes between the ports. When one port writes the mailbox that belongs to its partner, the partner's interrupt output goes active. The partner drops that interrupt by reading or otherwise accessing its own mailbox address.

Every control input is active low: select, write strobe, output enable and a per-port write-inhibit. The inhibit is meant to be driven by an external arbiter. It blocks both the array write and any mailbox notification from that port. Read data is registered. The mailbox words stay ordinary storage, and a system that does not use the interrupts treats them as plain RAM.

Top module: `mbox_dpram`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits (2048 x 8 by default). A port performs a read when sel_n=0, wr_n=1 and oe_n=0. The word at that address appears on its rdata one clock later. rdata keeps its last value in every cycle without a read.
- R2: A port performs a write when sel_n=0, wr_n=0 and hold_n=1. Both ports may write, or read, different addresses in the same cycle, and neither access affects the other.
- R3: A write by the right port to address 2**ADDR_W-2 (0x7FE) drives l_irq_n low from the next clock.
- R4: The left interrupt returns high on the clock after the left port accesses 0x7FE with sel_n=0 and oe_n=0. The level of wr_n does not matter for this clear.
- R5: A write by the left port to address 2**ADDR_W-1 (0x7FF) drives r_irq_n low. The right port clears it by accessing 0x7FF with sel_n=0 and oe_n=0.
- R6: Both mailbox addresses hold data like any other address, and either port can read what was written there.
- R7: While sel_n=1, a port does not write, does not change its rdata, and neither sets nor clears an interrupt.
- R8: While hold_n=0, a port's write leaves the array unchanged, and its write to the partner's mailbox does not set the partner's interrupt.
- R9: Reset drives both interrupt outputs high and both rdata to zero.
- R10: When a set and a clear of the same interrupt land in the same cycle, the interrupt is asserted.
- R11: A read of the address that the other port writes in the same cycle returns the word held before that write.
- R12: When both ports write the same address in the same cycle, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel_n | input | 1 | Left select, active low |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_hold_n | input | 1 | Left write inhibit, active low |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_sel_n | input | 1 | Right select, active low |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_hold_n | input | 1 | Right write inhibit, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Each result of this block is due exactly one clock after the stimulus that causes it. That holds for read data, for a mailbox interrupt being set and for it being cleared, and a written word can be read back from the following cycle. The bench drives inputs on the falling edge, so they are stable through the rising edge. A behavioural model then updates on that edge from the same inputs, and all four outputs are compared at the next falling edge. No result is ever looked for in the cycle of its own request.

// File: rtl/mbox_dpram_pkg.sv
package mbox_dpram_pkg;

   // Decoded per-port request, one bit per action.
   typedef struct packed {
      logic wr;    // array write allowed
      logic rd;    // read into the output register
      logic clr;   // access of this port's own mailbox
      logic set;   // allowed write of the partner's mailbox
   } port_req_t;

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
   import mbox_dpram_pkg::*;
#(
   parameter int unsigned ADDR_W   = 11,
   parameter int unsigned OWN_BOX  = 2046,
   parameter int unsigned PEER_BOX = 2047
) (
   input  logic              sel_n,
   input  logic              wr_n,
   input  logic              oe_n,
   input  logic              hold_n,
   input  logic [ADDR_W-1:0] addr,
   output port_req_t         req
);

   localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_BOX);
   localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_BOX);

   logic active;

   always_comb begin
      active  = !sel_n;
      req.wr  = active && !wr_n && hold_n;
      req.rd  = active && wr_n && !oe_n;
      req.clr = active && !oe_n && (addr == OWN_A);
      req.set = active && !wr_n && hold_n && (addr == PEER_A);
   end

endmodule

// File: rtl/mbox_dp_store.sv
module mbox_dp_store #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   // port a: wins a same-address write collision
   input  logic              a_we,
   input  logic              a_re,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   // port b
   input  logic              b_we,
   input  logic              b_re,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // a is written last, so it overrides b at the same address (R12)
   always_ff @(posedge clk) begin
      if (b_we) mem[b_addr] <= b_wdata;
      if (a_we) mem[a_addr] <= a_wdata;
   end

   // reads see the array before this edge's writes (R11)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_rdata <= '0;
         b_rdata <= '0;
      end else begin
         if (a_re) a_rdata <= mem[a_addr];
         if (b_re) b_rdata <= mem[b_addr];
      end
   end

   p_a_rd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !a_re |=> $stable(a_rdata));
   p_b_rd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !b_re |=> $stable(b_rdata));

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   irq <= 1'b0;
      else if (set) irq <= 1'b1;
      else if (clr) irq <= 1'b0;
   end

   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> irq);
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !irq);
   p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !clr) |=> $stable(irq));

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
   import mbox_dpram_pkg::*;
#(
   parameter int unsigned ADDR_W     = 11,
   parameter int unsigned DATA_W     = 8,
   parameter bit          MAILBOX_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel_n,
   input  logic              l_wr_n,
   input  logic              l_oe_n,
   input  logic              l_hold_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_irq_n,
   input  logic              r_sel_n,
   input  logic              r_wr_n,
   input  logic              r_oe_n,
   input  logic              r_hold_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_irq_n
);

   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned L_BOX = DEPTH - 2;   // written by right, read by left
   localparam int unsigned R_BOX = DEPTH - 1;   // written by left, read by right
   localparam logic [ADDR_W-1:0] L_BOX_A = ADDR_W'(L_BOX);
   localparam logic [ADDR_W-1:0] R_BOX_A = ADDR_W'(R_BOX);

   if (ADDR_W < 2 || DATA_W < 1) begin : g_bad_cfg
      $error("mbox_dpram: ADDR_W must be at least 2 and DATA_W at least 1");
   end

   port_req_t l_req, r_req;
   logic      l_irq, r_irq;

   mbox_port_decode #(.ADDR_W(ADDR_W), .OWN_BOX(L_BOX), .PEER_BOX(R_BOX)) u_l_dec (
      .sel_n(l_sel_n), .wr_n(l_wr_n), .oe_n(l_oe_n), .hold_n(l_hold_n),
      .addr(l_addr), .req(l_req)
   );

   mbox_port_decode #(.ADDR_W(ADDR_W), .OWN_BOX(R_BOX), .PEER_BOX(L_BOX)) u_r_dec (
      .sel_n(r_sel_n), .wr_n(r_wr_n), .oe_n(r_oe_n), .hold_n(r_hold_n),
      .addr(r_addr), .req(r_req)
   );

   mbox_dp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .a_we(l_req.wr), .a_re(l_req.rd), .a_addr(l_addr), .a_wdata(l_wdata), .a_rdata(l_rdata),
      .b_we(r_req.wr), .b_re(r_req.rd), .b_addr(r_addr), .b_wdata(r_wdata), .b_rdata(r_rdata)
   );

   if (MAILBOX_EN) begin : g_mbox
      mbox_flag u_l_flag (.clk(clk), .rst_n(rst_n), .set(r_req.set), .clr(l_req.clr), .irq(l_irq));
      mbox_flag u_r_flag (.clk(clk), .rst_n(rst_n), .set(l_req.set), .clr(r_req.clr), .irq(r_irq));
   end else begin : g_plain
      assign l_irq = 1'b0;
      assign r_irq = 1'b0;
   end

   assign l_irq_n = !l_irq;
   assign r_irq_n = !r_irq;

   // an interrupt can only fall after an uninhibited partner write to the box (R3, R8)
   p_l_flag_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(l_irq_n) |-> $past(!r_sel_n && !r_wr_n && r_hold_n && r_addr == L_BOX_A));
   // same for the right interrupt (R5, R8)
   p_r_flag_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(r_irq_n) |-> $past(!l_sel_n && !l_wr_n && l_hold_n && l_addr == R_BOX_A));
   // a deselected port leaves its read data alone (R7)
   p_l_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      l_sel_n |=> $stable(l_rdata));
   p_r_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      r_sel_n |=> $stable(r_rdata));

endmodule

// File: tb/mbox_dpram_tb.sv
`timescale 1ns/1ps
module mbox_dpram_tb;

   localparam int AW = 11;
   localparam int DW = 8;
   localparam int DEPTH = 1 << AW;
   localparam logic [AW-1:0] LBOX = AW'(DEPTH - 2);
   localparam logic [AW-1:0] RBOX = AW'(DEPTH - 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_sel_n = 1, l_wr_n = 1, l_oe_n = 1, l_hold_n = 1;
   logic r_sel_n = 1, r_wr_n = 1, r_oe_n = 1, r_hold_n = 1;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wdata = '0, r_wdata = '0;
   logic [DW-1:0] l_rdata, r_rdata;
   logic l_irq_n, r_irq_n;

   always #2 clk = ~clk;

   mbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_hold_n(l_hold_n),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
      .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_hold_n(r_hold_n),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
   );

   // reference model state
   logic [DW-1:0] ref_mem [DEPTH];
   logic [DW-1:0] exp_l, exp_r;
   logic          exp_lirq, exp_rirq;   // 1 = asserted
   int            total = 0, bad = 0;
   bit            done = 0;
   string         phase = "R9 reset";

   task automatic chk(string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: got %0h expected %0h", phase, what, act, exp);
      end
   endtask

   function automatic void model_edge();
      logic lw, rw, lr, rr, lset, lclr, rset, rclr;
      if (!rst_n) begin
         exp_l = '0; exp_r = '0; exp_lirq = 0; exp_rirq = 0;
         return;
      end
      lw = !l_sel_n && !l_wr_n && l_hold_n;
      rw = !r_sel_n && !r_wr_n && r_hold_n;
      lr = !l_sel_n && l_wr_n && !l_oe_n;
      rr = !r_sel_n && r_wr_n && !r_oe_n;
      if (lr) exp_l = ref_mem[l_addr];
      if (rr) exp_r = ref_mem[r_addr];
      if (rw) ref_mem[r_addr] = r_wdata;
      if (lw) ref_mem[l_addr] = l_wdata;
      lset = rw && r_addr == LBOX;
      lclr = !l_sel_n && !l_oe_n && l_addr == LBOX;
      rset = lw && l_addr == RBOX;
      rclr = !r_sel_n && !r_oe_n && r_addr == RBOX;
      if (lset) exp_lirq = 1; else if (lclr) exp_lirq = 0;
      if (rset) exp_rirq = 1; else if (rclr) exp_rirq = 0;
   endfunction

   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk("l_rdata", l_rdata, exp_l);
      chk("r_rdata", r_rdata, exp_r);
      chk("l_irq_n", l_irq_n, !exp_lirq);
      chk("r_irq_n", r_irq_n, !exp_rirq);
   endtask

   task automatic drv_l(logic s, logic w, logic o, logic h, logic [AW-1:0] a, logic [DW-1:0] d);
      l_sel_n = s; l_wr_n = w; l_oe_n = o; l_hold_n = h; l_addr = a; l_wdata = d;
   endtask
   task automatic drv_r(logic s, logic w, logic o, logic h, logic [AW-1:0] a, logic [DW-1:0] d);
      r_sel_n = s; r_wr_n = w; r_oe_n = o; r_hold_n = h; r_addr = a; r_wdata = d;
   endtask
   task automatic idle();
      drv_l(1, 1, 1, 1, '0, '0);
      drv_r(1, 1, 1, 1, '0, '0);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      idle();
      repeat (3) step();
      rst_n = 1;
      step();

      // R1 R2: fill, both ports writing different addresses each cycle
      phase = "R1 R2 fill";
      for (int i = 0; i < DEPTH / 2; i++) begin
         drv_l(0, 0, 1, 1, AW'(2 * i), DW'((2 * i) ^ 8'h5A));
         drv_r(0, 0, 1, 1, AW'(2 * i + 1), DW'((2 * i + 1) * 7));
         step();
      end
      phase = "R1 R2 read";
      for (int i = 0; i < 32; i++) begin
         drv_l(0, 1, 0, 1, AW'(i * 37), '0);
         drv_r(0, 1, 0, 1, AW'(i * 53 + 1), '0);
         step();
      end
      idle(); step();

      // R3: right writes the left mailbox
      phase = "R3 set left irq";
      drv_r(0, 0, 1, 1, LBOX, 8'hA5); step();
      idle(); step();
      // R6: mailbox is plain storage, right reads it without clearing
      phase = "R6 read left box by right";
      drv_r(0, 1, 0, 1, LBOX, '0); step();
      idle(); step();
      // R4 R8: left access with wr_n low and inhibited clears, no write
      phase = "R4 R8 clear with write strobe";
      drv_l(0, 0, 0, 0, LBOX, 8'h3C); step();
      idle(); step();
      phase = "R6 R8 box unchanged";
      drv_l(0, 1, 0, 1, LBOX, '0); step();
      idle(); step();

      // R5: left writes the right mailbox, right clears by reading
      phase = "R5 set right irq";
      drv_l(0, 0, 1, 1, RBOX, 8'h96); step();
      idle(); step();
      phase = "R5 R6 clear right irq";
      drv_r(0, 1, 0, 1, RBOX, '0); step();
      idle(); step();

      // R7: deselected port does nothing
      phase = "R7 deselected write";
      drv_r(1, 0, 0, 1, LBOX, 8'h11); step();
      drv_l(1, 1, 0, 1, 11'h010, '0); step();
      phase = "R7 deselected clear";
      drv_r(0, 0, 1, 1, LBOX, 8'h22); step();
      drv_l(1, 1, 0, 1, LBOX, '0); step();
      drv_l(0, 1, 0, 1, LBOX, '0); step();
      idle(); step();

      // R8: inhibited mailbox write sets nothing
      phase = "R8 inhibited box write";
      drv_r(0, 0, 1, 0, LBOX, 8'h77); step();
      drv_l(0, 0, 1, 0, RBOX, 8'h88); step();
      idle(); step();
      drv_l(0, 1, 0, 1, LBOX, '0); drv_r(0, 1, 0, 1, RBOX, '0); step();
      idle(); step();

      // R10: set and clear in the same cycle
      phase = "R10 set beats clear";
      drv_l(0, 0, 1, 1, RBOX, 8'h44); drv_r(0, 1, 0, 1, RBOX, '0); step();
      idle(); step();
      drv_r(0, 1, 0, 1, RBOX, '0); step();
      idle(); step();

      // R11: read old data during the other port's write
      phase = "R11 read during write";
      drv_l(0, 1, 0, 1, 11'h100, '0); drv_r(0, 0, 1, 1, 11'h100, 8'hE1); step();
      drv_l(0, 1, 0, 0, 11'h100, '0); drv_r(0, 0, 1, 0, 11'h100, 8'h0F); step();
      drv_r(0, 1, 0, 1, 11'h100, '0); idle(); drv_r(0, 1, 0, 1, 11'h100, '0); step();
      idle(); step();

      // R12: same-address double write
      phase = "R12 collision";
      drv_l(0, 0, 1, 1, 11'h200, 8'hC3); drv_r(0, 0, 1, 1, 11'h200, 8'h3C); step();
      drv_l(0, 1, 0, 1, 11'h200, '0); drv_r(0, 1, 0, 1, 11'h200, '0); step();
      idle(); step();

      // mixed traffic concentrated on a small window around the mailboxes
      phase = "R2 R10 R11 R12 random";
      for (int i = 0; i < 4000; i++) begin
         logic [AW-1:0] la, ra;
         la = ($urandom % 2) ? AW'(DEPTH - 1 - ($urandom % 4)) : AW'($urandom);
         ra = ($urandom % 2) ? AW'(DEPTH - 1 - ($urandom % 4)) : la;
         drv_l($urandom % 4 == 0, $urandom % 2, $urandom % 2, $urandom % 5 != 0, la, DW'($urandom));
         drv_r($urandom % 4 == 0, $urandom % 2, $urandom % 2, $urandom % 5 != 0, ra, DW'($urandom));
         step();
      end
      idle(); step();

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule